// File: doc/BRIEF.md
# Three-Wire Serial Shift Interface

This block is a small byte-wide shift engine for SPI-style transfers on three wires: a serial clock, a data input and a data output. An 8-bit shift register sends its most significant bit on `sdo` and takes new bits from `sdi` at the least significant end. The clock that drives the shifting comes from one of two sources. One is the external `sck_in` pin, which is brought into the system clock domain before its edges are detected. The other is a software strobe: each strobe write flips `sck_out`, and every flip is one clock edge.

A 4-bit edge counter advances on every edge of the selected clock, both rising and falling. After 16 edges, which is eight full clock pulses, the counter wraps to zero. On that wrap it raises an overflow flag and copies the completed byte into a buffer register. The next transfer can then begin before software has read the buffer.

Software uses a plain register port of four byte-wide locations. The port has no back-pressure: it takes a write in every cycle that `bus_wr` is high, and `bus_rdata` follows `bus_addr` combinationally. Software loads the byte to send, reads the received byte and the buffer, clears the flag, sets the counter, and picks the clock mode and the clock source.

Top module: `tw_shift_port`

## Requirements
- R1: After reset the data register, the buffer, the counter, the overflow flag, `sck_out` and `sdo` are all 0. The control register reads 0, which means clock mode 0 with the external clock source.
- R2: In clock mode 0 (control bit 0 = 0), `sdi` is sampled on each rising edge of the selected clock. On each falling edge the data register shifts left by one, and the sampled bit enters at bit 0. `sdo` always equals bit 7 of the data register.
- R3: In clock mode 1 (control bit 0 = 1), sampling takes place on falling edges and shifting on rising edges. In this mode the clock idles high, so the first edge of a byte is a sample edge.
- R4: The counter (status bits 3:0) adds one on every edge of the selected clock. From 15 it wraps to 0, and that wrap sets the overflow flag (status bit 7 and the `ovf_flag` pin).
- R5: On the wrapping edge the buffer (address 1) takes the data register value that results from that edge. It keeps this value until the next wrap. A write to address 1 has no effect.
- R6: A status write (address 2) with bit 7 = 1 clears the flag. A status write with bit 7 = 0 leaves the flag as it is. If a wrap and a clear happen in the same cycle, the flag is set.
- R7: A status write with bit 6 = 1 loads the counter from bits 3:0. If an edge happens in the same cycle, the loaded value wins.
- R8: A control write (address 3) stores bit 0 as the mode and bit 1 as the source (1 = software). If bit 2 = 1, the write flips `sck_out`. When the source is software, that flip is one clock edge: rising if `sck_out` was 0, falling if it was 1. If bit 2 = 0, the write sets `sck_out` to the written mode bit and produces no edge. Bit 2 always reads back as 0.
- R9: With the external source selected, a change on `sck_in` that is first captured at system clock edge k takes effect at edge k+2. With the software source selected, changes on `sck_in` have no effect.
- R10: A write to address 0 loads the data register. `sdo` shows the new bit 7 from the next cycle. If a shift edge happens in the same cycle, the write wins.
- R11: The read data is: address 0, the data register; address 1, the buffer; address 2, {flag, 0, 0, 0, counter}; address 3, {0, 0, 0, 0, 0, 0, source, mode}.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data (combinational on address) |
| sck_in | input | 1 | External serial clock |
| sck_out | output | 1 | Software-generated serial clock |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out (data register MSB) |
| ovf_flag | output | 1 | Byte-complete overflow flag |

## Verification
Two pairs of functions can land in the same cycle. The first is a counter wrap that sets the flag while a status write clears it. The second is a clock edge that advances the counter while a status write loads it. A single bus cannot carry both a strobe and a status write in one cycle, so the bench provokes these collisions with the external clock. It moves `sck_in` and then times the status write to reach the block exactly two system edges after the synchronizer captures the change. It then judges the result by reading the flag and the counter back through the status register: the flag must be set, and the counter must hold the loaded value rather than the incremented one.

// File: rtl/tw_shift_pkg.sv
package tw_shift_pkg;
  localparam logic [1:0] ADDR_DATA = 2'd0;
  localparam logic [1:0] ADDR_BUF  = 2'd1;
  localparam logic [1:0] ADDR_STAT = 2'd2;
  localparam logic [1:0] ADDR_CTRL = 2'd3;

  localparam int CTRL_MODE   = 0;
  localparam int CTRL_SRC    = 1;
  localparam int CTRL_STROBE = 2;

  typedef struct packed {
    logic rise;
    logic fall;
  } clk_edge_t;
endpackage

// File: rtl/tw_clk_front.sv
module tw_clk_front
  import tw_shift_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      sck_in,
  input  logic      src_sw,
  input  logic      ctrl_wr,
  input  logic      strobe,
  input  logic      idle_lvl,
  output logic      sck_out,
  output clk_edge_t ev
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   last_q;
  logic                   soft_q;
  logic                   ext_rise, ext_fall, sw_rise, sw_fall;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sck_in;
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], sck_in};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q <= 1'b0;
      soft_q <= 1'b0;
    end else begin
      last_q <= sync_q[SYNC_STAGES-1];
      if (ctrl_wr) soft_q <= strobe ? ~soft_q : idle_lvl;
    end
  end

  assign ext_rise = sync_q[SYNC_STAGES-1] & ~last_q;
  assign ext_fall = ~sync_q[SYNC_STAGES-1] & last_q;
  assign sw_rise  = ctrl_wr & strobe & ~soft_q;
  assign sw_fall  = ctrl_wr & strobe & soft_q;

  always_comb begin
    ev.rise = src_sw ? sw_rise : ext_rise;
    ev.fall = src_sw ? sw_fall : ext_fall;
  end

  assign sck_out = soft_q;
endmodule

// File: rtl/tw_edge_counter.sv
module tw_edge_counter #(
  parameter int CNT_W = 4,
  parameter int EDGES = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             flag_clr,
  output logic [CNT_W-1:0] cnt,
  output logic             flag,
  output logic             wrap
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(EDGES - 1);
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  assign wrap = step && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      flag <= 1'b0;
    end else begin
      if (load)      cnt <= load_val;
      else if (wrap) cnt <= '0;
      else if (step) cnt <= cnt + ONE;
      if (wrap)          flag <= 1'b1;
      else if (flag_clr) flag <= 1'b0;
    end
  end
endmodule

// File: rtl/tw_shift_core.sv
module tw_shift_core
  import tw_shift_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode,
  input  clk_edge_t         ev,
  input  logic              sdi,
  input  logic              wr_data,
  input  logic [DATA_W-1:0] wr_val,
  input  logic              wrap,
  output logic [DATA_W-1:0] shreg,
  output logic [DATA_W-1:0] buffer
);
  logic              samp_q;
  logic              sample_edge, shift_edge;
  logic [DATA_W-1:0] shifted, after_edge;

  assign sample_edge = mode ? ev.fall : ev.rise;
  assign shift_edge  = mode ? ev.rise : ev.fall;
  assign shifted     = {shreg[DATA_W-2:0], samp_q};
  assign after_edge  = shift_edge ? shifted : shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      samp_q <= 1'b0;
      shreg  <= '0;
      buffer <= '0;
    end else begin
      if (sample_edge) samp_q <= sdi;
      if (wr_data)         shreg <= wr_val;
      else if (shift_edge) shreg <= shifted;
      if (wrap) buffer <= after_edge;
    end
  end
endmodule

// File: rtl/tw_shift_port.sv
module tw_shift_port
  import tw_shift_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              sck_in,
  output logic              sck_out,
  input  logic              sdi,
  output logic              sdo,
  output logic              ovf_flag
);
  localparam int EDGES = 2 * DATA_W;
  localparam int CNT_W = $clog2(EDGES);
  localparam int FLAG_BIT = DATA_W - 1;
  localparam int LOAD_BIT = DATA_W - 2;

  logic              mode_q, src_q;
  logic              wr_data, wr_stat, wr_ctrl;
  logic              cnt_load, flag_clr, wrap;
  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] shreg, buffer;
  clk_edge_t         ev;
  logic              step;

  assign wr_data  = bus_wr && (bus_addr == ADDR_DATA);
  assign wr_stat  = bus_wr && (bus_addr == ADDR_STAT);
  assign wr_ctrl  = bus_wr && (bus_addr == ADDR_CTRL);
  assign cnt_load = wr_stat && bus_wdata[LOAD_BIT];
  assign flag_clr = wr_stat && bus_wdata[FLAG_BIT];
  assign step     = ev.rise | ev.fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 1'b0;
      src_q  <= 1'b0;
    end else if (wr_ctrl) begin
      mode_q <= bus_wdata[CTRL_MODE];
      src_q  <= bus_wdata[CTRL_SRC];
    end
  end

  tw_clk_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
    .clk      (clk),
    .rst_n    (rst_n),
    .sck_in   (sck_in),
    .src_sw   (src_q),
    .ctrl_wr  (wr_ctrl),
    .strobe   (bus_wdata[CTRL_STROBE]),
    .idle_lvl (bus_wdata[CTRL_MODE]),
    .sck_out  (sck_out),
    .ev       (ev)
  );

  tw_edge_counter #(.CNT_W(CNT_W), .EDGES(EDGES)) u_count (
    .clk      (clk),
    .rst_n    (rst_n),
    .step     (step),
    .load     (cnt_load),
    .load_val (bus_wdata[CNT_W-1:0]),
    .flag_clr (flag_clr),
    .cnt      (cnt_q),
    .flag     (ovf_flag),
    .wrap     (wrap)
  );

  tw_shift_core #(.DATA_W(DATA_W)) u_core (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode    (mode_q),
    .ev      (ev),
    .sdi     (sdi),
    .wr_data (wr_data),
    .wr_val  (bus_wdata),
    .wrap    (wrap),
    .shreg   (shreg),
    .buffer  (buffer)
  );

  assign sdo = shreg[DATA_W-1];

  always_comb begin
    unique case (bus_addr)
      ADDR_DATA: bus_rdata = shreg;
      ADDR_BUF:  bus_rdata = buffer;
      ADDR_STAT: bus_rdata = {ovf_flag, {(DATA_W-1-CNT_W){1'b0}}, cnt_q};
      default:   bus_rdata = {{(DATA_W-2){1'b0}}, src_q, mode_q};
    endcase
  end
endmodule

// File: rtl/tw_shift_port_chk.sv
module tw_shift_port_chk #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              step,
  input logic              cnt_load,
  input logic              flag_clr,
  input logic [CNT_W-1:0]  cnt_q,
  input logic              ovf_flag,
  input logic              bus_wr,
  input logic [1:0]        bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              sdo,
  input logic              sck_out
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(2 * DATA_W - 1);
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  // R4
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !cnt_load && cnt_q != LAST) |=> cnt_q == $past(cnt_q) + ONE);

  // R4
  cnt_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !cnt_load && cnt_q == LAST) |=> cnt_q == '0);

  // R6
  flag_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && cnt_q == LAST) |=> ovf_flag);

  // R6
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(step && cnt_q == LAST) && !flag_clr) |=> ovf_flag == $past(ovf_flag));

  // R7
  cnt_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_load |=> cnt_q == $past(bus_wdata[CNT_W-1:0]));

  // R10
  data_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 2'd0) |=> sdo == $past(bus_wdata[DATA_W-1]));

  // R8
  strobe_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 2'd3 && bus_wdata[2]) |=> sck_out != $past(sck_out));
endmodule

bind tw_shift_port tw_shift_port_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .step      (step),
  .cnt_load  (cnt_load),
  .flag_clr  (flag_clr),
  .cnt_q     (cnt_q),
  .ovf_flag  (ovf_flag),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .sdo       (sdo),
  .sck_out   (sck_out)
);

// File: tb/tw_shift_port_test.sv
module tw_shift_port_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       sck_in = 1'b0;
  logic       sck_out;
  logic       sdi = 1'b0;
  logic       sdo;
  logic       ovf_flag;

  int n_checks = 0;
  int n_fails  = 0;

  always #4 clk = ~clk;

  tw_shift_port uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sck_in(sck_in),
    .sck_out(sck_out), .sdi(sdi), .sdo(sdo), .ovf_flag(ovf_flag)
  );

  function automatic logic [7:0] mid_value(logic [7:0] tx, logic [7:0] rx, int j);
    logic [15:0] cat;
    cat = {tx, rx};
    return 8'(cat >> (8 - j));
  endfunction

  function automatic logic [7:0] stat_value(logic flag, logic [3:0] cnt);
    return {flag, 3'b000, cnt};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic ext_level(input logic lvl);
    @(negedge clk);
    sck_in = lvl;
    repeat (4) @(negedge clk);
  endtask

  task automatic sw_transfer(input logic mode, input logic [7:0] tx, input logic [7:0] rx);
    logic [7:0] rd;
    bus_write(2'd3, {6'd0, 1'b1, mode});
    bus_write(2'd2, 8'hC0);
    bus_write(2'd0, tx);
    for (int j = 0; j < 8; j++) begin
      check(mode ? "R3 sdo bit" : "R2 sdo bit", sdo, mid_value(tx, rx, j) >> 7);
      sdi = rx[7-j];
      bus_write(2'd3, {5'd0, 1'b1, 1'b1, mode});
      bus_write(2'd3, {5'd0, 1'b1, 1'b1, mode});
      if (j < 7) begin
        bus_read(2'd2, rd);
        check("R4 count per pulse", rd, stat_value(1'b0, 4'(2 * (j + 1))));
      end
    end
    bus_read(2'd0, rd);
    check(mode ? "R3 received byte" : "R2 received byte", rd, rx);
    bus_read(2'd1, rd);
    check("R5 buffer copy", rd, rx);
    bus_read(2'd2, rd);
    check("R4 wrap and flag", rd, stat_value(1'b1, 4'd0));
    check("R4 ovf_flag pin", ovf_flag, 1'b1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    logic [7:0] tx, rx;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      bus_read(2'(a), rd);
      check("R1 reset register", rd, 8'h00);
    end
    check("R1 reset sdo", sdo, 1'b0);
    check("R1 reset sck_out", sck_out, 1'b0);
    check("R1 reset flag", ovf_flag, 1'b0);

    // R10 data write updates sdo
    bus_write(2'd0, 8'hA5);
    check("R10 sdo after write", sdo, 1'b1);
    bus_write(2'd0, 8'h5A);
    check("R10 sdo after write", sdo, 1'b0);
    bus_read(2'd0, rd);
    check("R11 data readback", rd, 8'h5A);

    // R5 buffer is read only
    bus_write(2'd1, 8'hFF);
    bus_read(2'd1, rd);
    check("R5 buffer write ignored", rd, 8'h00);

    // R11 control readback, strobe reads 0
    bus_write(2'd3, 8'h07);
    bus_read(2'd3, rd);
    check("R11 control readback", rd, 8'h03);

    // R8 strobe and idle level
    bus_write(2'd3, 8'h02);
    check("R8 idle level mode 0", sck_out, 1'b0);
    bus_write(2'd2, 8'hC0);
    bus_write(2'd3, 8'h06);
    check("R8 strobe toggles", sck_out, 1'b1);
    bus_read(2'd2, rd);
    check("R8 strobe counts an edge", rd, stat_value(1'b0, 4'd1));
    bus_write(2'd3, 8'h03);
    check("R8 idle level mode 1", sck_out, 1'b1);
    bus_write(2'd3, 8'h02);
    check("R8 idle set low", sck_out, 1'b0);
    bus_read(2'd2, rd);
    check("R8 idle set no edge", rd, stat_value(1'b0, 4'd1));

    // R7 counter load
    bus_write(2'd2, 8'h45);
    bus_read(2'd2, rd);
    check("R7 counter load", rd, stat_value(1'b0, 4'd5));

    // R2 R3 directed and random software transfers
    sw_transfer(1'b0, 8'h80, 8'h01);
    sw_transfer(1'b1, 8'h01, 8'h80);
    for (int t = 0; t < 8; t++) begin
      tx = 8'($urandom);
      rx = 8'($urandom);
      sw_transfer(1'($urandom), tx, rx);
    end

    // R9 external clock transfer, mode 0
    bus_write(2'd3, 8'h00);
    bus_write(2'd2, 8'hC0);
    tx = 8'h3C; rx = 8'hC9;
    bus_write(2'd0, tx);
    for (int j = 0; j < 8; j++) begin
      sdi = rx[7-j];
      ext_level(1'b1);
      ext_level(1'b0);
    end
    bus_read(2'd0, rd);
    check("R9 external received byte", rd, rx);
    bus_read(2'd1, rd);
    check("R9 external buffer", rd, rx);
    bus_read(2'd2, rd);
    check("R9 external wrap", rd, stat_value(1'b1, 4'd0));

    // R6 wrap and clear in the same cycle
    bus_write(2'd2, 8'hCF);
    @(negedge clk);
    sck_in = 1'b1;
    @(posedge clk);
    @(posedge clk);
    bus_write(2'd2, 8'h80);
    bus_read(2'd2, rd);
    check("R6 set wins over clear", rd, stat_value(1'b1, 4'd0));

    // R7 edge and load in the same cycle
    @(negedge clk);
    sck_in = 1'b0;
    @(posedge clk);
    @(posedge clk);
    bus_write(2'd2, 8'h43);
    bus_read(2'd2, rd);
    check("R7 load wins over edge", rd, stat_value(1'b1, 4'd3));

    // R6 write-one-to-clear
    bus_write(2'd2, 8'h00);
    check("R6 zero write keeps flag", ovf_flag, 1'b1);
    bus_write(2'd2, 8'h80);
    check("R6 one write clears flag", ovf_flag, 1'b0);

    // R9 external pin ignored under software source
    bus_write(2'd3, 8'h02);
    ext_level(1'b1);
    ext_level(1'b0);
    bus_read(2'd2, rd);
    check("R9 sck_in ignored", rd, stat_value(1'b0, 4'd3));

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end
endmodule